// File: doc/BRIEF.md
# ATA PIO strobe timing generator

This block paces the register-cycle strobes of a parallel ATA host with two channels, each carrying two devices, which makes four device units. Software loads one 16-bit timing word per unit and a control byte that switches IORDY flow control off for chosen units. A channel accepts one request at a time through a valid/acknowledge pair, with a device number and a direction. It drives the active-low read or write strobe for the programmed active time, then holds the bus idle for the programmed recovery time. Both times are counted in bus clocks.

Each timing byte stores its two lengths as offsets from a constant. A zeroed word therefore gives the slowest timing. Reads and writes have separate bytes. When IORDY is honoured for a unit and is low at the end of the programmed active time, the strobe stays low until IORDY goes high. The two channels run independently of each other.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: After reset both strobes of every channel are high, no done pulse is present, every timing word is zero (17 active and 16 recovery clocks in both directions) and IORDY is honoured for every unit.
- R2: The strobe stays low for 17 minus the timing nibble clocks. Reads use bits 3:0 of the unit's word and writes use bits 11:8, which gives a range of 2 to 17 clocks.
- R3: Recovery lasts 16 minus the timing nibble clocks. Reads use bits 7:4 and writes use bits 15:12, which gives a range of 1 to 16 clocks. Recovery begins on the clock after the strobe rises. The channel acknowledges a new request in the first clock after recovery ends.
- R4: A word write to byte address 0x44 + 2*unit loads that unit's timing word. The unit number is 2*channel + device. A write to any other address, odd addresses included, changes no timing.
- R5: Control bit 4+unit at address 0x42 set to 1 disables IORDY sampling for that unit. When the bit is 0 and IORDY is low at the end of the programmed active time, the strobe stays low through every clock in which IORDY is low and rises after the first clock with IORDY high. The programmed minimum still applies.
- R6: A control byte write takes effect only in a clock where both bits of the write-buffer busy input are 0. Until then the previous control value stays in force.
- R7: A one-clock done pulse appears in the first clock in which the strobe is high again. On a read, the data bus value present at the rising edge that ends the strobe is held on the read-data output.
- R8: The two channels accept, time and finish their cycles independently. Each uses the word of its own unit.
- R9: A channel never drives both strobes low at once. It acknowledges only while both of its strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data (control byte in bits 7:0) |
| wb_busy | input | 2 | Posted write-buffer busy flags |
| req_valid | input | 2 | Request valid, one bit per channel |
| req_dev | input | 2 | Device number, one bit per channel |
| req_write | input | 2 | 1 = write cycle, 0 = read cycle, per channel |
| req_ack | output | 2 | Request accepted in this clock, per channel |
| iordy | input | 2 | IORDY from each channel's cable |
| bus_din | input | 32 | Data bus per channel (channel c in bits 16c+15:16c) |
| ior_n | output | 2 | Active-low read strobe per channel |
| iow_n | output | 2 | Active-low write strobe per channel |
| cyc_done | output | 2 | End-of-strobe pulse per channel |
| rd_data | output | 32 | Captured read data per channel |

## Verification
The bench measures strobe-low and recovery lengths at the nibble extremes 0 and 15 and with mixed nibbles. A design that swapped nibbles, swapped bytes or shared one byte for both directions would show wrong lengths at these points. It writes to odd and neighbouring addresses, where a loose decoder would corrupt a unit's word. It raises IORDY before, at and after the programmed minimum with the control bit both clear and set. It writes the control byte while either busy flag is set, so a control change that took effect too early shows up as a shortened strobe. Overlapping cycles on both channels expose any state shared between the engines.

// File: rtl/ata_pio_strobe_pkg.sv
package ata_pio_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_t;

  // Strobe-low clocks encoded by a nibble: 17 - n (2..17)
  function automatic logic [4:0] active_clocks(input logic [3:0] nib);
    return 5'd17 - {1'b0, nib};
  endfunction

  // Recovery clocks encoded by a nibble: 16 - n (1..16)
  function automatic logic [4:0] recovery_clocks(input logic [3:0] nib);
    return 5'd16 - {1'b0, nib};
  endfunction

  // Reads use the low byte, writes the high byte
  function automatic logic [7:0] dir_byte(input logic [15:0] word, input logic is_wr);
    return is_wr ? word[15:8] : word[7:0];
  endfunction

endpackage

// File: rtl/ata_tmg_regs.sv
module ata_tmg_regs #(
  parameter int NUM_UNITS   = 4,
  parameter int ADDR_W      = 8,
  parameter int TW          = 16,
  parameter int TIMING_BASE = 'h44,
  parameter int CTRL_ADDR   = 'h42,
  parameter int CTRL_LSB    = 4,
  parameter int BUSY_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [TW-1:0]           cfg_wdata,
  input  logic [BUSY_W-1:0]       wb_busy,
  output logic [NUM_UNITS*TW-1:0] tword_all,
  output logic [NUM_UNITS-1:0]    iordy_off
);

  logic                 ctl_pending;
  logic [NUM_UNITS-1:0] ctl_staged;
  logic                 ctl_hit;
  logic                 ctl_commit;

  assign ctl_hit    = cfg_we && (cfg_addr == ADDR_W'(CTRL_ADDR));
  assign ctl_commit = ctl_pending && (wb_busy == '0);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic word_hit;
    assign word_hit = cfg_we && (cfg_addr == ADDR_W'(TIMING_BASE + 2 * u));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tword_all[u*TW +: TW] <= '0;
      else if (word_hit) tword_all[u*TW +: TW] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pending <= 1'b0;
      ctl_staged  <= '0;
      iordy_off   <= '0;
    end else begin
      if (ctl_commit) begin
        iordy_off   <= ctl_staged;
        ctl_pending <= 1'b0;
      end
      if (ctl_hit) begin
        ctl_staged  <= cfg_wdata[CTRL_LSB +: NUM_UNITS];
        ctl_pending <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ata_tmg_engine.sv
module ata_tmg_engine
  import ata_pio_strobe_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [TW-1:0] tword,
  input  logic          iordy_off,
  input  logic          iordy,
  input  logic [DW-1:0] bus_din,
  output logic          req_ack,
  output logic          ior_n,
  output logic          iow_n,
  output logic          done,
  output logic [DW-1:0] rdata
);

  phase_t      phase;
  logic [4:0]  cnt;
  logic [4:0]  rec_len;
  logic        is_wr;
  logic        honor_rdy;
  logic [7:0]  sel_byte;
  logic [4:0]  act_len_in;
  logic [4:0]  rec_len_in;
  logic        ev_accept;
  logic        ev_release;

  assign sel_byte   = dir_byte(tword, req_write);
  assign act_len_in = active_clocks(sel_byte[3:0]);
  assign rec_len_in = recovery_clocks(sel_byte[7:4]);

  assign req_ack    = req_valid && (phase == PH_IDLE);
  assign ev_accept  = req_ack;
  assign ev_release = (phase == PH_ACTIVE) && (cnt == '0) && (!honor_rdy || iordy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rec_len   <= '0;
      is_wr     <= 1'b0;
      honor_rdy <= 1'b0;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (ev_accept) begin
            phase     <= PH_ACTIVE;
            cnt       <= act_len_in - 5'd1;
            rec_len   <= rec_len_in;
            is_wr     <= req_write;
            honor_rdy <= !iordy_off;
            ior_n     <= req_write;
            iow_n     <= !req_write;
          end
        end
        PH_ACTIVE: begin
          if (cnt != '0) begin
            cnt <= cnt - 5'd1;
          end else if (ev_release) begin
            phase <= PH_RECOVER;
            cnt   <= rec_len - 5'd1;
            ior_n <= 1'b1;
            iow_n <= 1'b1;
            done  <= 1'b1;
            if (!is_wr) rdata <= bus_din;
          end
        end
        PH_RECOVER: begin
          if (cnt != '0) cnt <= cnt - 5'd1;
          else           phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen #(
  parameter int NUM_CH      = 2,
  parameter int DEV_PER_CH  = 2,
  parameter int DW          = 16,
  parameter int ADDR_W      = 8,
  parameter int TIMING_BASE = 'h44,
  parameter int CTRL_ADDR   = 'h42,
  parameter int BUSY_W      = 2,
  localparam int NUM_UNITS  = NUM_CH * DEV_PER_CH,
  localparam int DEV_W      = (DEV_PER_CH > 1) ? $clog2(DEV_PER_CH) : 1,
  localparam int UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int TW         = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [TW-1:0]        cfg_wdata,
  input  logic [BUSY_W-1:0]    wb_busy,
  input  logic [NUM_CH-1:0]    req_valid,
  input  logic [NUM_CH*DEV_W-1:0] req_dev,
  input  logic [NUM_CH-1:0]    req_write,
  output logic [NUM_CH-1:0]    req_ack,
  input  logic [NUM_CH-1:0]    iordy,
  input  logic [NUM_CH*DW-1:0] bus_din,
  output logic [NUM_CH-1:0]    ior_n,
  output logic [NUM_CH-1:0]    iow_n,
  output logic [NUM_CH-1:0]    cyc_done,
  output logic [NUM_CH*DW-1:0] rd_data
);

  logic [NUM_UNITS*TW-1:0] tword_all;
  logic [NUM_UNITS-1:0]    iordy_off;

  ata_tmg_regs #(
    .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .TW(TW),
    .TIMING_BASE(TIMING_BASE), .CTRL_ADDR(CTRL_ADDR),
    .CTRL_LSB(4), .BUSY_W(BUSY_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wb_busy(wb_busy),
    .tword_all(tword_all), .iordy_off(iordy_off)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [UNIT_W-1:0] unit_sel;
    logic [TW-1:0]     tword;
    logic              unit_rdy_off;

    assign unit_sel = UNIT_W'(c * DEV_PER_CH) + UNIT_W'(req_dev[c*DEV_W +: DEV_W]);

    always_comb begin
      tword        = '0;
      unit_rdy_off = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (unit_sel == UNIT_W'(u)) begin
          tword        = tword_all[u*TW +: TW];
          unit_rdy_off = iordy_off[u];
        end
      end
    end

    ata_tmg_engine #(.TW(TW), .DW(DW)) eng_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[c]), .req_write(req_write[c]),
      .tword(tword), .iordy_off(unit_rdy_off), .iordy(iordy[c]),
      .bus_din(bus_din[c*DW +: DW]),
      .req_ack(req_ack[c]), .ior_n(ior_n[c]), .iow_n(iow_n[c]),
      .done(cyc_done[c]), .rdata(rd_data[c*DW +: DW])
    );
  end

endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ior_n,
  input logic [NUM_CH-1:0] iow_n,
  input logic [NUM_CH-1:0] req_ack,
  input logic [NUM_CH-1:0] cyc_done
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     low_run <= '0;
      else if (!ior_n[c] || !iow_n[c]) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
      else                            low_run <= '0;
    end

    // R9: one strobe at a time
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ior_n[c] && !iow_n[c]));

    // R9: acknowledge only while idle on the bus
    assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack[c] |-> (ior_n[c] && iow_n[c]));

    // R7: done is a single-clock pulse with strobes released
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done[c] |=> !cyc_done[c]);

    assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done[c] |-> (ior_n[c] && iow_n[c]));

    // R2: a strobe never ends before the two-clock minimum
    assert_min_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done[c] |-> (low_run >= 8'd2));

    // R3: at least one recovery clock follows every strobe
    assert_min_recovery_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done[c] |=> (ior_n[c] && iow_n[c]));
  end

endmodule

bind ata_pio_strobe_gen ata_pio_strobe_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ior_n(ior_n), .iow_n(iow_n),
  .req_ack(req_ack), .cyc_done(cyc_done)
);

// File: tb/ata_pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module ata_pio_strobe_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  wb_busy = '0;
  logic [1:0]  req_valid = '0;
  logic [1:0]  req_dev = '0;
  logic [1:0]  req_write = '0;
  logic [1:0]  req_ack;
  logic [1:0]  iordy = 2'b11;
  logic [31:0] bus_din = '0;
  logic [1:0]  ior_n, iow_n, cyc_done;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] shadow [4];

  always #2 clk = ~clk;

  ata_pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wb_busy(wb_busy), .req_valid(req_valid),
    .req_dev(req_dev), .req_write(req_write), .req_ack(req_ack),
    .iordy(iordy), .bus_din(bus_din), .ior_n(ior_n), .iow_n(iow_n),
    .cyc_done(cyc_done), .rd_data(rd_data)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cycles, 150000);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench restatement of the encoding: low nibble active, high nibble recovery
  function automatic int want_act(input logic [15:0] w, input bit wr);
    int n = wr ? int'(w[11:8]) : int'(w[3:0]);
    return 17 - n;
  endfunction
  function automatic int want_rec(input logic [15:0] w, input bit wr);
    int n = wr ? int'(w[15:12]) : int'(w[7:4]);
    return 16 - n;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_word(input int u, input logic [15:0] d);
    cfg_write(8'(8'h44 + 2 * u), d);
    shadow[u] = d;
  endtask

  // One bus cycle; k>0 keeps IORDY low until the k-th strobe-low clock
  task automatic do_cycle(input int ch, input int dev, input bit wr,
                          input logic [15:0] din, input int k,
                          input int exp_act, input int exp_rec, input string tag);
    int n = 0;
    int r = 0;
    @(negedge clk);
    req_dev[ch] = dev[0]; req_write[ch] = wr; req_valid[ch] = 1'b1;
    bus_din[ch*16 +: 16] = din;
    if (k > 0) iordy[ch] = 1'b0;
    #1;
    while (!req_ack[ch]) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[ch] = 1'b0;
    check(wr ? ior_n[ch] : iow_n[ch], {tag, " R9 other strobe high"}, 0, 1);
    while ((wr ? iow_n[ch] : ior_n[ch]) == 1'b0 && n < 400) begin
      n++;
      if (n == k) iordy[ch] = 1'b1;
      @(negedge clk);
    end
    iordy[ch] = 1'b1;
    check(n == exp_act, {tag, " R2 active clocks"}, n, exp_act);
    check(cyc_done[ch] == 1'b1, {tag, " R7 done pulse"}, int'(cyc_done[ch]), 1);
    if (!wr)
      check(rd_data[ch*16 +: 16] == din, {tag, " R7 read data"},
            int'(rd_data[ch*16 +: 16]), int'(din));
    while (r < 400) begin
      req_valid[ch] = 1'b1; #1;
      if (req_ack[ch]) begin
        req_valid[ch] = 1'b0;
        break;
      end
      req_valid[ch] = 1'b0;
      r++;
      @(negedge clk);
    end
    check(r == exp_rec, {tag, " R3 recovery clocks"}, r, exp_rec);
  endtask

  initial begin
    void'($urandom(32'h5EED_0415));
    for (int u = 0; u < 4; u++) shadow[u] = '0;
    repeat (3) @(negedge clk);
    check(ior_n == 2'b11 && iow_n == 2'b11, "R1 strobes high in reset", int'({ior_n, iow_n}), 15);
    rst_n = 1'b1;
    @(negedge clk);
    check(ior_n == 2'b11 && iow_n == 2'b11 && cyc_done == 2'b00, "R1 idle after reset",
          int'({ior_n, iow_n, cyc_done}), 60);

    // R1: default timing and IORDY honoured
    do_cycle(0, 0, 0, 16'hA5C3, 0, 17, 16, "R1 default read");
    do_cycle(1, 1, 1, 16'h0000, 0, 17, 16, "R1 default write");
    do_cycle(1, 0, 0, 16'h1111, 20, 20, 16, "R1 default iordy");

    // R2/R3/R4: mixed nibbles, separate bytes per direction
    set_word(1, 16'h3CA5);
    do_cycle(0, 1, 0, 16'hBEEF, 0, 12, 6, "R4 unit1 read");
    do_cycle(0, 1, 1, 16'h0000, 0, 5, 13, "R4 unit1 write");
    do_cycle(0, 0, 0, 16'h1234, 0, 17, 16, "R4 unit0 untouched");
    set_word(2, 16'hFFFF);
    set_word(3, 16'hF00F);
    do_cycle(1, 0, 0, 16'h0F0F, 0, 2, 1, "R2 unit2 fastest read");
    do_cycle(1, 0, 1, 16'h0000, 0, 2, 1, "R3 unit2 fastest write");
    do_cycle(1, 1, 0, 16'h7777, 0, 2, 16, "R2 unit3 read");
    do_cycle(1, 1, 1, 16'h0000, 0, 17, 1, "R3 unit3 write");

    // R4: stray addresses leave the words alone
    cfg_write(8'h45, 16'h1234);
    cfg_write(8'h40, 16'h5678);
    cfg_write(8'h4C, 16'h9ABC);
    cfg_write(8'h49, 16'h0000);
    do_cycle(1, 0, 0, 16'h2222, 0, 2, 1, "R4 stray writes ignored");

    // R5: IORDY stretch and minimum
    do_cycle(1, 0, 0, 16'h3333, 7, 7, 1, "R5 iordy stretch");
    do_cycle(1, 0, 1, 16'h0000, 1, 2, 1, "R5 iordy min kept");

    // R6: control held while write buffers busy (unit2 -> bit 6)
    wb_busy = 2'b01;
    cfg_write(8'h42, 16'h0040);
    repeat (3) @(negedge clk);
    do_cycle(1, 0, 0, 16'h4444, 9, 9, 1, "R6 busy0 holds control");
    wb_busy = 2'b10;
    do_cycle(1, 0, 0, 16'h4545, 6, 6, 1, "R6 busy1 holds control");
    wb_busy = 2'b00;
    repeat (2) @(negedge clk);
    do_cycle(1, 0, 0, 16'h5555, 9, 2, 1, "R5 iordy ignored");
    do_cycle(1, 1, 0, 16'h5656, 5, 5, 16, "R5 other unit still honours");

    // R8: both channels at once
    fork
      do_cycle(0, 1, 0, 16'hC0DE, 0, 12, 6, "R8 ch0 concurrent");
      do_cycle(1, 1, 1, 16'h0000, 0, 17, 1, "R8 ch1 concurrent");
    join

    // Random words and directions
    cfg_write(8'h42, 16'h0000);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      int u = int'($urandom_range(3, 0));
      bit wr = 1'($urandom_range(1, 0));
      logic [15:0] w = 16'($urandom);
      logic [15:0] d = 16'($urandom);
      set_word(u, w);
      do_cycle(u / 2, u % 2, wr, d, 0, want_act(w, wr), want_rec(w, wr), "R2 random");
    end

    summary();
  end

endmodule